// File: doc/BRIEF.md
# Multiplexed-Address DRAM Array Model

This block is a synthesizable, clock-sampled model of a small dynamic memory chip. The pins follow the older asynchronous style. One address bus carries the row number first and the column number second. Four active-low strobes steer each access: row select, column select, write enable and output enable. The data bus is split into an input word, an output word and an output-enable flag that a pad ring would use to drive a shared bidirectional line. The cell array is held in registers and sized by parameters. The default is four rows of four 8-bit supercells on a 2-bit address bus.

The strobes are sampled on the clock, and their edges are found against the value seen one cycle earlier. A falling row strobe latches the row number. It also copies that whole row into a row buffer and drains the row in the array, because reading a cell destroys its charge. A falling column strobe latches the column number. With write enable high it starts a read: the buffered supercell is driven out whenever both the column strobe and the output enable are low, so the output enable may come before or after the column strobe. With write enable low it writes the input word into the buffered supercell instead. While the row strobe stays low, further column pulses reach other supercells of the open row (page mode). A rising row strobe writes the whole buffer back into the latched row.

The controller has four states:
- `S_IDLE`: no row is open.
- `S_OPEN`: a row is open and no column is selected.
- `S_READ`: a column read is active.
- `S_WRITE`: a column write is active.

The state changes on these transitions:
- Row activate: `S_IDLE` to `S_OPEN` on a falling row strobe.
- Column read: `S_OPEN` to `S_READ` on a falling column strobe with write enable high.
- Column write: `S_OPEN` to `S_WRITE` on a falling column strobe with write enable low.
- Column release: `S_READ` or `S_WRITE` back to `S_OPEN` on a rising column strobe.
- Row close: any open state to `S_IDLE` on a rising row strobe. This transition performs the write-back.

Top module: `mux_dram_core`

## Requirements
- R1: After reset `dout_en_o` is 0, `dout_o` is 0, and every supercell of the array reads back as 0.
- R2: On the clock edge where `ras_n_i` is first seen low, the row number on `addr_i` is latched and that whole row is copied into the row buffer.
- R3: On the edge where `cas_n_i` is first seen low with `we_n_i` high and a row open, the column number on `addr_i` is latched. From the cycle after that edge, `dout_o` carries the buffered supercell at the latched column whenever `oe_n_i` is also low.
- R4: `dout_en_o` is 1 only during a column read while both `cas_n_i` and `oe_n_i` are low. Whenever `dout_en_o` is 0, `dout_o` is 0. With `oe_n_i` held high through the falling column strobe and lowered later, the output turns on at that later point.
- R5: On the edge where `cas_n_i` is first seen low with `we_n_i` low and a row open, `din_i` is written into the row-buffer supercell at the column on `addr_i`, and `dout_en_o` stays 0 for the whole write.
- R6: While `ras_n_i` stays low, repeated column pulses reach other supercells of the same open row. The values on `addr_i` during those pulses never change the open row.
- R7: On the edge where `ras_n_i` is first seen high after a row was opened, the row buffer, including every supercell written during the page, is stored back into the latched row. Other rows are left unchanged.
- R8: A column pulse while no row is open is ignored: it produces no output and writes nothing.
- R9: A rising row strobe closes the row even while `cas_n_i` is still low. The output turns off, and the write-back of R7 still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for strobes and state |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W (2) | Multiplexed address: the row at the row strobe, then the column at the column strobe |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low, sampled at the falling column strobe |
| oe_n_i | input | 1 | Output enable, active low |
| din_i | input | WORD_W (8) | Write data |
| dout_o | output | WORD_W (8) | Read data, 0 when not driven |
| dout_en_o | output | 1 | High when the data pins should be driven |

## Verification
The bench builds the block with its default parameters: four rows, four columns and 8-bit words on a 2-bit address bus. At that size every row and every column can be named, so the bench's reference copy of the array covers the whole store. Writes to the corner cells (row 0 column 0, row 3 column 3) and reads of cells never written are both reachable. The small geometry also lets one open page touch every column. This exposes any case where a column address leaks into the row latch, or where write-back misses a supercell.

// File: rtl/mdram_pkg.sv
package mdram_pkg;

    // Controller states of the access sequencer.
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_OPEN  = 2'd1,
        S_READ  = 2'd2,
        S_WRITE = 2'd3
    } dram_state_e;

    // Index of each strobe in the edge detector vector.
    localparam int STB_RAS = 0;
    localparam int STB_CAS = 1;
    localparam int STB_NUM = 2;

endpackage

// File: rtl/mdram_edge.sv
// Edge finder for active-low strobes, one register per strobe.
module mdram_edge #(
    parameter int NUM = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] strobe_n_i,
    output logic [NUM-1:0] fall_o,
    output logic [NUM-1:0] rise_o
);

    logic [NUM-1:0] prev_q;

    for (genvar s = 0; s < NUM; s++) begin : g_stb
        // Strobes idle high, so the history resets to the inactive level.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[s] <= 1'b1;
            else        prev_q[s] <= strobe_n_i[s];
        end

        assign fall_o[s] =  prev_q[s] & ~strobe_n_i[s];
        assign rise_o[s] = ~prev_q[s] &  strobe_n_i[s];
    end

endmodule

// File: rtl/mdram_cell_array.sv
// Register-held storage array. A row read drains the row, a write-back restores it.
module mdram_cell_array #(
    parameter int ROWS   = 4,
    parameter int COLS   = 4,
    parameter int WORD_W = 8,
    localparam int ROW_AW = $clog2(ROWS),
    localparam int ROW_W  = COLS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_AW-1:0] rd_row_i,
    input  logic              drain_en_i,
    output logic [ROW_W-1:0]  row_data_o,
    input  logic              wb_en_i,
    input  logic [ROW_AW-1:0] wb_row_i,
    input  logic [ROW_W-1:0]  wb_data_i
);

    logic [ROW_W-1:0] mem_q [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[r] <= '0;
            end else if (wb_en_i && (wb_row_i == ROW_AW'(r))) begin
                mem_q[r] <= wb_data_i;
            end else if (drain_en_i && (rd_row_i == ROW_AW'(r))) begin
                mem_q[r] <= '0;
            end
        end
    end

    assign row_data_o = mem_q[rd_row_i];

    // R7: a row is never drained and restored in the same cycle.
    p_port_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(drain_en_i && wb_en_i));

    // R7: restored row holds the written-back value afterwards.
    p_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_i |=> (mem_q[$past(wb_row_i)] == $past(wb_data_i)));

endmodule

// File: rtl/mdram_row_buf.sv
// Row buffer: loaded as a whole, written and read one supercell at a time.
module mdram_row_buf #(
    parameter int COLS   = 4,
    parameter int WORD_W = 8,
    localparam int COL_AW = $clog2(COLS),
    localparam int ROW_W  = COLS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en_i,
    input  logic [ROW_W-1:0]  load_data_i,
    input  logic              wr_en_i,
    input  logic [COL_AW-1:0] wr_col_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic [COL_AW-1:0] rd_col_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic [ROW_W-1:0]  all_o
);

    logic [WORD_W-1:0] cell_q [COLS];

    for (genvar c = 0; c < COLS; c++) begin : g_col
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q[c] <= '0;
            end else if (load_en_i) begin
                cell_q[c] <= load_data_i[c*WORD_W +: WORD_W];
            end else if (wr_en_i && (wr_col_i == COL_AW'(c))) begin
                cell_q[c] <= wr_data_i;
            end
        end
        assign all_o[c*WORD_W +: WORD_W] = cell_q[c];
    end

    assign rd_data_o = cell_q[rd_col_i];

    // R2: a load captures the full row that was presented.
    p_load_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en_i |=> (all_o == $past(load_data_i)));

    // R5: a column write lands in the addressed supercell.
    p_col_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !load_en_i) |=> (cell_q[$past(wr_col_i)] == $past(wr_data_i)));

endmodule

// File: rtl/mux_dram_core.sv
// Multiplexed-address DRAM array model: row strobe opens a page into the
// row buffer, column strobes read or write supercells of that page.
module mux_dram_core
    import mdram_pkg::*;
#(
    parameter int ROWS   = 4,
    parameter int COLS   = 4,
    parameter int WORD_W = 8,
    localparam int ROW_AW = $clog2(ROWS),
    localparam int COL_AW = $clog2(COLS),
    localparam int ADDR_W = (ROW_AW > COL_AW) ? ROW_AW : COL_AW,
    localparam int ROW_W  = COLS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ras_n_i,
    input  logic              cas_n_i,
    input  logic              we_n_i,
    input  logic              oe_n_i,
    input  logic [WORD_W-1:0] din_i,
    output logic [WORD_W-1:0] dout_o,
    output logic              dout_en_o
);

    dram_state_e state_q, state_d;

    logic [STB_NUM-1:0] stb_fall, stb_rise;
    logic               ras_fall, ras_rise, cas_fall, cas_rise;

    logic               load_en, wb_en, col_wr_en;
    logic [ROW_AW-1:0]  row_q;
    logic [COL_AW-1:0]  col_q;
    logic [ROW_AW-1:0]  addr_row;
    logic [COL_AW-1:0]  addr_col;
    logic [ROW_W-1:0]   array_row, buf_all;
    logic [WORD_W-1:0]  buf_word;

    assign addr_row = addr_i[ROW_AW-1:0];
    assign addr_col = addr_i[COL_AW-1:0];

    mdram_edge #(.NUM(STB_NUM)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_n_i ({cas_n_i, ras_n_i}),
        .fall_o     (stb_fall),
        .rise_o     (stb_rise)
    );

    assign ras_fall = stb_fall[STB_RAS];
    assign ras_rise = stb_rise[STB_RAS];
    assign cas_fall = stb_fall[STB_CAS];
    assign cas_rise = stb_rise[STB_CAS];

    mdram_cell_array #(.ROWS(ROWS), .COLS(COLS), .WORD_W(WORD_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_row_i   (addr_row),
        .drain_en_i (load_en),
        .row_data_o (array_row),
        .wb_en_i    (wb_en),
        .wb_row_i   (row_q),
        .wb_data_i  (buf_all)
    );

    mdram_row_buf #(.COLS(COLS), .WORD_W(WORD_W)) u_rowbuf (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en_i   (load_en),
        .load_data_i (array_row),
        .wr_en_i     (col_wr_en),
        .wr_col_i    (addr_col),
        .wr_data_i   (din_i),
        .rd_col_i    (col_q),
        .rd_data_o   (buf_word),
        .all_o       (buf_all)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state and datapath controls.
    always_comb begin
        state_d   = state_q;
        load_en   = 1'b0;
        wb_en     = 1'b0;
        col_wr_en = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                // Column pulses are ignored here: no row is open.
                if (ras_fall) begin
                    load_en = 1'b1;
                    state_d = S_OPEN;
                end
            end
            S_OPEN: begin
                if (ras_rise) begin
                    wb_en   = 1'b1;
                    state_d = S_IDLE;
                end else if (cas_fall) begin
                    if (!we_n_i) begin
                        col_wr_en = 1'b1;
                        state_d   = S_WRITE;
                    end else begin
                        state_d   = S_READ;
                    end
                end
            end
            S_READ, S_WRITE: begin
                if (ras_rise) begin
                    wb_en   = 1'b1;
                    state_d = S_IDLE;
                end else if (cas_rise) begin
                    state_d = S_OPEN;
                end
            end
        endcase
    end

    // Address latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else begin
            if (load_en) row_q <= addr_row;
            if (state_q == S_OPEN && cas_fall && !ras_rise) col_q <= addr_col;
        end
    end

    // Outputs.
    always_comb begin
        dout_en_o = (state_q == S_READ) && !cas_n_i && !oe_n_i;
        dout_o    = dout_en_o ? buf_word : '0;
    end

    // R4: data pins driven only with both column strobe and output enable low.
    p_drive_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en_o |-> (!oe_n_i && !cas_n_i));

    // R5: a column write never drives the data pins.
    p_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WRITE) |-> !dout_en_o);

    // R8: with the row strobe high, the idle state is kept whatever the column strobe does.
    p_cas_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && ras_n_i) |=> (state_q == S_IDLE));

    // R7/R9: a high row strobe always closes an open row.
    p_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && ras_n_i) |=> (state_q == S_IDLE));

    // R6: the latched row holds for the whole page.
    p_row_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> $stable(row_q));

    // R2: a falling row strobe from idle opens a page.
    p_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && $past(ras_n_i) && !ras_n_i) |=> (state_q == S_OPEN));

endmodule

// File: tb/mux_dram_core_tb_top.sv
module mux_dram_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] addr;
    logic       ras_n, cas_n, we_n, oe_n;
    logic [7:0] din;
    logic [7:0] dout;
    logic       dout_en;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [7:0] model [4][4];

    always #5 clk = ~clk;

    mux_dram_core dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr),
        .ras_n_i   (ras_n),
        .cas_n_i   (cas_n),
        .we_n_i    (we_n),
        .oe_n_i    (oe_n),
        .din_i     (din),
        .dout_o    (dout),
        .dout_en_o (dout_en)
    );

    // Vector fields: {is_write, row[1:0], col[1:0], data[7:0]}.
    localparam logic [12:0] VEC [12] = '{
        {1'b1, 2'd0, 2'd0, 8'hA5},
        {1'b1, 2'd3, 2'd3, 8'h3C},
        {1'b1, 2'd2, 2'd1, 8'h81},
        {1'b0, 2'd0, 2'd0, 8'h00},
        {1'b0, 2'd3, 2'd3, 8'h00},
        {1'b0, 2'd2, 2'd1, 8'h00},
        {1'b0, 2'd1, 2'd2, 8'h00},
        {1'b1, 2'd0, 2'd0, 8'h5A},
        {1'b0, 2'd0, 2'd0, 8'h00},
        {1'b1, 2'd1, 2'd3, 8'hFF},
        {1'b0, 2'd1, 2'd3, 8'h00},
        {1'b0, 2'd3, 2'd0, 8'h00}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive pins at the falling edge, then wait past the next rising edge.
    task automatic drive(input logic r, input logic c, input logic w, input logic o,
                         input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a; din = d;
        @(posedge clk);
        #1;
    endtask

    task automatic idle_pins();
        drive(1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 8'h00);
    endtask

    task automatic access(input logic wr, input logic [1:0] row, input logic [1:0] col,
                          input logic [7:0] d, input string tag);
        drive(1'b0, 1'b1, 1'b1, 1'b1, row, 8'h00);
        if (wr) begin
            drive(1'b0, 1'b0, 1'b0, 1'b1, col, d);
            check({tag, " write keeps output off"}, {31'd0, dout_en}, 32'd0);
            model[row][col] = d;
        end else begin
            drive(1'b0, 1'b0, 1'b1, 1'b0, col, 8'h00);
            check({tag, " read enable"}, {31'd0, dout_en}, 32'd1);
            check({tag, " read data"}, {24'd0, dout}, {24'd0, model[row][col]});
        end
        drive(1'b0, 1'b1, 1'b1, 1'b1, col, 8'h00);
        idle_pins();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0; din = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                model[r][c] = 8'h00;
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual=expired expected=finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0;
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0; din = '0;
        do_reset();
        #1;
        // R1: quiet outputs after reset.
        check("R1 reset dout_en", {31'd0, dout_en}, 32'd0);
        check("R1 reset dout", {24'd0, dout}, 32'd0);

        // Vector walk: R2 R3 R5 R7, and R1 for cells never written.
        for (int i = 0; i < 12; i++) begin
            access(VEC[i][12], VEC[i][11:10], VEC[i][9:8], VEC[i][7:0], "R2/R3/R5/R7 vector");
        end

        // R6: page mode, fill row 1 under one row strobe, column addresses vary.
        drive(1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 8'h00);
        for (int c = 0; c < 4; c++) begin
            drive(1'b0, 1'b0, 1'b0, 1'b1, 2'(c), 8'h10 + 8'(c));
            model[1][c] = 8'h10 + 8'(c);
            drive(1'b0, 1'b1, 1'b1, 1'b1, 2'(c), 8'h00);
        end
        drive(1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 8'h00);
        check("R6 page read col3", {24'd0, dout}, {24'd0, model[1][3]});
        drive(1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 8'h00);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 8'h00);
        check("R6 page read col0 stays on row1", {24'd0, dout}, {24'd0, model[1][0]});
        drive(1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 8'h00);
        idle_pins();
        // R7: page writes survive the close; neighbouring rows untouched.
        access(1'b0, 2'd1, 2'd2, 8'h00, "R7 reopen row1");
        access(1'b0, 2'd0, 2'd0, 8'h00, "R7 other row kept");

        // R4: late output enable during a read.
        drive(1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 8'h00);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 2'd3, 8'h00);
        check("R4 oe high keeps output off", {31'd0, dout_en}, 32'd0);
        check("R4 disabled output is zero", {24'd0, dout}, 32'd0);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 8'h00);
        check("R4 late oe turns output on", {31'd0, dout_en}, 32'd1);
        check("R4 late oe data", {24'd0, dout}, {24'd0, model[3][3]});
        drive(1'b0, 1'b1, 1'b1, 1'b0, 2'd3, 8'h00);
        check("R4 cas high turns output off", {31'd0, dout_en}, 32'd0);
        idle_pins();

        // R8: column pulse with no open row.
        drive(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'hEE);
        check("R8 no output without row", {31'd0, dout_en}, 32'd0);
        drive(1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 8'hEE);
        check("R8 no output on held cas", {31'd0, dout_en}, 32'd0);
        idle_pins();
        access(1'b0, 2'd0, 2'd0, 8'h00, "R8 cell unchanged");

        // R9: row closes while the column strobe is still low.
        drive(1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 8'h00);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 8'h77);
        model[2][2] = 8'h77;
        drive(1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 8'h00);
        check("R9 closed row drives nothing", {31'd0, dout_en}, 32'd0);
        idle_pins();
        access(1'b0, 2'd2, 2'd2, 8'h00, "R9 write-back on close");
        access(1'b0, 2'd2, 2'd1, 8'h00, "R9 row neighbour kept");

        // R1: reset clears the array.
        do_reset();
        access(1'b0, 2'd2, 2'd2, 8'h00, "R1 cleared after reset");
        access(1'b0, 2'd1, 2'd3, 8'h00, "R1 cleared after reset");

        done = 1'b1;
        finish_run();
    end

endmodule